// File: doc/BRIEF.md
# Sequential Rate-to-Mantissa Encoder

This block turns a requested traffic rate into the exponent, mantissa and divider-exponent fields that a token-bucket shaper uses. The encoded rate is `floor(clk * ((256 + m) << e) / ((ticks << d) * 256))`. Here `clk` is the clock frequency, `ticks` is the time-wheel resolution, `e` is the exponent (0..15), `m` is the mantissa (0..255) and `d` is the divider exponent (0..12). The engine finds the fields with a step-by-step search that makes one comparison per cycle. It then reports the rate that the chosen fields really give, or it raises an error flag when the request cannot be encoded.

A second mode encodes a burst size, where the value is `floor(((256 + m) << (e + 1)) / 256)`. In this mode the clock and tick inputs play no part. The search runs the same way, with the divider exponent held at zero.

The caller presents its operands with a one-cycle `start_i`, then waits for the one-cycle `done_o`. The result outputs hold their values until the next request completes.

Top module: `rate_mant_encoder`

## Requirements
- R1: While reset is held and after it is released, `busy_o`, `done_o` and `err_o` are low and the exponent, mantissa, divider and achieved outputs are zero.
- R2: `start_i` is accepted only when the engine is idle. `busy_o` is high from the cycle after acceptance up to and including the result cycle. `done_o` is high for exactly one cycle, and the result is valid in that cycle.
- R3: A `start_i` pulse seen while the engine is busy is ignored, whatever the other inputs carry. The result of the request in progress is unchanged.
- R4: In rate mode (`burst_mode_i` = 0, `ticks_i` ≥ 1), the request is rejected in either of two cases: the target is below the encoded rate for e=0, m=0, d=12, or it is above the encoded rate for e=15, m=255, d=0. A rejected request sets `err_o` and reports zero for every field and for the achieved value.
- R5: In rate mode, a target at or below `floor(clk/ticks)` gives exponent 0. The divider exponent is the first d, counting up from 0, for which the target is not below `floor(clk/(ticks<<d))`.
- R6: In rate mode, a target above `floor(clk/ticks)` gives divider exponent 0. The exponent is the first e, counting down from 15, for which the target is not below `floor(clk*2^e/ticks)`.
- R7: With e and d fixed, the mantissa is the first m, counting down from 255, for which the target is not below the encoded rate for (e, m, d).
- R8: For an accepted rate request, `achieved_o` equals the encoded rate formula evaluated at the reported e, m and d.
- R9: In burst mode (`burst_mode_i` = 1), `clk_hz_i` and `ticks_i` are ignored and the search works as follows:
  - A target outside 2..130816 is rejected as in R4.
  - The exponent counts down from 15 while the target is below 2^(e+1).
  - The mantissa counts down from 255 while the target is below `floor(((256+m)<<(e+1))/256)`.
  - The divider exponent is 0.
  - `achieved_o` is the burst formula evaluated at the chosen e and m.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, taken only when idle |
| burst_mode_i | input | 1 | 0: rate encoding, 1: burst encoding |
| target_i | input | V_W | Requested rate or burst size |
| clk_hz_i | input | C_W | Clock frequency used by the rate formula |
| ticks_i | input | T_W | Time-wheel resolution in clock ticks (≥ 1 in rate mode) |
| busy_o | output | 1 | Engine is working on a request |
| done_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | Last request was out of range |
| exp_o | output | 4 | Chosen exponent |
| mant_o | output | 8 | Chosen mantissa |
| dexp_o | output | 4 | Chosen divider exponent |
| achieved_o | output | V_W | Value really produced by the chosen fields |

## Verification
The bench sweeps targets geometrically across several clock and tick pairs and through the whole burst range. It aims at the following corner cases, with the failure each one would expose:

- Exact range edges: the lowest and highest legal values, and one past each. An off-by-one comparison either rejects a legal target or accepts an illegal one.
- The path threshold `floor(clk/ticks)` and one above it. A wrong threshold selects the wrong search, giving a nonzero divider exponent on the fast path or a nonzero exponent on the slow path.
- Targets so small that the divider climbs to its limit, and targets that drive the mantissa down to zero. These expose floor-versus-exact comparison errors that shift the mantissa by one and then skew the achieved value.
- Extra start pulses with different operands while busy, and burst requests carrying garbage clock and tick values. Either would corrupt the result if it leaked in.

// File: rtl/rme_pkg.sv
package rme_pkg;

    localparam int EXP_W     = 4;
    localparam int MANT_W    = 8;
    localparam int DEXP_W    = 4;
    localparam int EXP_TOP   = 15;
    localparam int MANT_TOP  = 255;
    localparam int DEXP_TOP  = 12;
    // scale applied by the mantissa denominator (x256)
    localparam int FRAC_SH   = 8;
    // burst mode reuses the rate formula with clk = 2, ticks = 1
    localparam int BURST_CLK = 2;
    localparam int BURST_TCK = 1;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_MUL,
        PH_CHK,
        PH_DSRCH,
        PH_ESRCH,
        PH_MSRCH,
        PH_QUOT,
        PH_DONE
    } phase_e;

endpackage

// File: rtl/rme_range_check.sv
module rme_range_check
    import rme_pkg::*;
#(
    parameter int C_W = 32,
    parameter int KW  = 81
) (
    input  logic           burst_i,
    input  logic [C_W-1:0] clk_hz_i,
    input  logic [KW-1:0]  vt_i,       // target * ticks
    input  logic [KW-1:0]  v1t_i,      // (target + 1) * ticks
    output logic           too_low_o,
    output logic           too_high_o,
    output logic           slow_o
);

    logic [KW-1:0] c_w;
    logic [KW-1:0] c_top;
    logic [KW-1:0] lo_lhs;

    always_comb begin
        c_w   = KW'(clk_hz_i);
        // clk * 511 * 2^15 : numerator of the largest encodable rate
        c_top = ((c_w << 9) - c_w) << EXP_TOP;
        // target < floor(N/D)  <=>  (target+1)*D <= N
        if (burst_i) begin
            lo_lhs = v1t_i << FRAC_SH;
        end else begin
            lo_lhs = v1t_i << (DEXP_TOP + FRAC_SH);
        end
        too_low_o  = lo_lhs <= (c_w << FRAC_SH);
        // target > floor(N/D)  <=>  target*D > N
        too_high_o = (vt_i << FRAC_SH) > c_top;
        slow_o     = !burst_i && (vt_i <= c_w);
    end

endmodule

// File: rtl/rme_divider.sv
module rme_divider #(
    parameter int W = 56
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] quo_o
);

    localparam int CNT_W = $clog2(W + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     rem;
        logic [W-1:0]     q;
        logic [W-1:0]     den;
    } div_t;

    div_t s_d, s_q;
    logic [W:0] part;
    logic       bit_n;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        part     = {s_q.rem, s_q.q[W-1]};
        bit_n    = part >= {1'b0, s_q.den};
        if (s_q.busy) begin
            if (bit_n) begin
                s_d.rem = W'(part - {1'b0, s_q.den});
            end else begin
                s_d.rem = part[W-1:0];
            end
            s_d.q   = {s_q.q[W-2:0], bit_n};
            s_d.cnt = s_q.cnt - 1'b1;
            if (s_q.cnt == CNT_W'(1)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end else if (start_i) begin
            s_d.busy = 1'b1;
            s_d.rem  = '0;
            s_d.q    = num_i;
            s_d.den  = den_i;
            s_d.cnt  = CNT_W'(W);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o = s_q.busy;
    assign done_o = s_q.done;
    assign quo_o  = s_q.q;

    // R8: quotient strobe is a single cycle
    a_r8_div_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R8: the encoder never launches a division while one is running
    a_r8_div_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);

endmodule

// File: rtl/rate_mant_encoder.sv
module rate_mant_encoder
    import rme_pkg::*;
#(
    parameter int C_W = 32,
    parameter int T_W = 12,
    parameter int V_W = C_W + 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              burst_mode_i,
    input  logic [V_W-1:0]    target_i,
    input  logic [C_W-1:0]    clk_hz_i,
    input  logic [T_W-1:0]    ticks_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [EXP_W-1:0]  exp_o,
    output logic [MANT_W-1:0] mant_o,
    output logic [DEXP_W-1:0] dexp_o,
    output logic [V_W-1:0]    achieved_o
);

    localparam int NW = C_W + 24;                   // clk*511*2^15
    localparam int PW = V_W + T_W + 1;              // (target+1)*ticks
    localparam int KW = (PW + DEXP_TOP + FRAC_SH > NW) ? PW + DEXP_TOP + FRAC_SH : NW;
    localparam int DW = (NW > T_W + DEXP_TOP + FRAC_SH) ? NW : T_W + DEXP_TOP + FRAC_SH;

    typedef struct packed {
        phase_e            ph;
        logic              burst;
        logic [V_W-1:0]    v;
        logic [C_W-1:0]    c;
        logic [T_W-1:0]    t;
        logic [KW-1:0]     vt;
        logic [KW-1:0]     v1t;
        logic [KW-1:0]     n;
        logic [EXP_W-1:0]  e;
        logic [MANT_W-1:0] m;
        logic [DEXP_W-1:0] d;
        logic              r_err;
        logic [EXP_W-1:0]  r_e;
        logic [MANT_W-1:0] r_m;
        logic [DEXP_W-1:0] r_d;
        logic [V_W-1:0]    r_ach;
    } eng_t;

    eng_t s_d, s_q;

    logic          too_low, too_high, slow_path;
    logic          div_start, div_busy, div_done;
    logic [DW-1:0] div_num, div_den, div_quo;
    logic [KW-1:0] c_full, c511, lhs, prod;
    logic [4:0]    dsh, esh;

    rme_range_check #(.C_W(C_W), .KW(KW)) u_range (
        .burst_i   (s_q.burst),
        .clk_hz_i  (s_q.c),
        .vt_i      (s_q.vt),
        .v1t_i     (s_q.v1t),
        .too_low_o (too_low),
        .too_high_o(too_high),
        .slow_o    (slow_path)
    );

    rme_divider #(.W(DW)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(div_start),
        .num_i  (div_num),
        .den_i  (div_den),
        .busy_o (div_busy),
        .done_o (div_done),
        .quo_o  (div_quo)
    );

    always_comb begin
        s_d       = s_q;
        div_start = 1'b0;
        dsh       = {1'b0, s_q.d} + 5'(FRAC_SH);
        esh       = {1'b0, s_q.e} + 5'(FRAC_SH);
        c_full    = KW'(s_q.c);
        c511      = (c_full << 9) - c_full;
        lhs       = s_q.v1t << dsh;          // (target+1)*ticks*2^(d+8)
        prod      = KW'(s_q.v) * KW'(s_q.t);
        div_num   = s_q.n[DW-1:0];
        div_den   = DW'(s_q.t) << dsh;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    s_d.ph    = PH_MUL;
                    s_d.burst = burst_mode_i;
                    s_d.v     = target_i;
                    s_d.c     = burst_mode_i ? C_W'(BURST_CLK) : clk_hz_i;
                    s_d.t     = burst_mode_i ? T_W'(BURST_TCK) : ticks_i;
                end
            end
            PH_MUL: begin
                s_d.vt  = prod;
                s_d.v1t = prod + KW'(s_q.t);
                s_d.ph  = PH_CHK;
            end
            PH_CHK: begin
                s_d.d = '0;
                if (too_low || too_high) begin
                    s_d.r_err = 1'b1;
                    s_d.r_e   = '0;
                    s_d.r_m   = '0;
                    s_d.r_d   = '0;
                    s_d.r_ach = '0;
                    s_d.ph    = PH_DONE;
                end else if (slow_path) begin
                    s_d.e  = '0;
                    s_d.ph = PH_DSRCH;
                end else begin
                    s_d.e  = EXP_W'(EXP_TOP);
                    s_d.ph = PH_ESRCH;
                end
            end
            PH_DSRCH: begin
                if (lhs <= (c_full << FRAC_SH) && s_q.d != DEXP_W'(DEXP_TOP)) begin
                    s_d.d = s_q.d + 1'b1;
                end else begin
                    s_d.n  = c511;
                    s_d.m  = MANT_W'(MANT_TOP);
                    s_d.ph = PH_MSRCH;
                end
            end
            PH_ESRCH: begin
                if (lhs <= (c_full << esh) && s_q.e != '0) begin
                    s_d.e = s_q.e - 1'b1;
                end else begin
                    s_d.n  = c511 << s_q.e;
                    s_d.m  = MANT_W'(MANT_TOP);
                    s_d.ph = PH_MSRCH;
                end
            end
            PH_MSRCH: begin
                if (lhs <= s_q.n && s_q.m != '0) begin
                    s_d.m = s_q.m - 1'b1;
                    s_d.n = s_q.n - (c_full << s_q.e);
                end else begin
                    div_start = 1'b1;
                    s_d.ph    = PH_QUOT;
                end
            end
            PH_QUOT: begin
                if (div_done) begin
                    s_d.r_err = 1'b0;
                    s_d.r_e   = s_q.e;
                    s_d.r_m   = s_q.m;
                    s_d.r_d   = s_q.d;
                    s_d.r_ach = div_quo[V_W-1:0];
                    s_d.ph    = PH_DONE;
                end
            end
            PH_DONE: begin
                s_d.ph = PH_IDLE;
            end
            default: begin
                s_d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o     = s_q.ph != PH_IDLE;
    assign done_o     = s_q.ph == PH_DONE;
    assign err_o      = s_q.r_err;
    assign exp_o      = s_q.r_e;
    assign mant_o     = s_q.r_m;
    assign dexp_o     = s_q.r_d;
    assign achieved_o = s_q.r_ach;

    a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r2_busy_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);
    a_r2_div_running: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_QUOT && !div_done) |-> div_busy);
    a_r3_operands_held: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph != PH_IDLE && s_q.ph != PH_DONE) |=> ($stable(s_q.v) && $stable(s_q.burst)));
    a_r4_reject_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> (exp_o == '0 && mant_o == '0 && dexp_o == '0 && achieved_o == '0));
    a_r5_dexp_cap: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> dexp_o <= DEXP_W'(DEXP_TOP));
    a_r6_fast_no_divider: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && exp_o != '0) |-> dexp_o == '0);
    a_r9_burst_no_divider: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && s_q.burst) |-> dexp_o == '0);

endmodule

// File: tb/tb_rate_mant_encoder.sv
module tb_rate_mant_encoder;

    localparam int C_W = 16;
    localparam int T_W = 8;
    localparam int V_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             burst_mode_i = 1'b0;
    logic [V_W-1:0]   target_i = '0;
    logic [C_W-1:0]   clk_hz_i = '0;
    logic [T_W-1:0]   ticks_i = '0;
    logic             busy_o, done_o, err_o;
    logic [3:0]       exp_o, dexp_o;
    logic [7:0]       mant_o;
    logic [V_W-1:0]   achieved_o;

    int checks = 0;
    int errors = 0;
    int runs   = 0;
    int cyc    = 0;

    always #2 clk = ~clk;

    rate_mant_encoder #(.C_W(C_W), .T_W(T_W), .V_W(V_W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .burst_mode_i(burst_mode_i),
        .target_i(target_i), .clk_hz_i(clk_hz_i), .ticks_i(ticks_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .exp_o(exp_o),
        .mant_o(mant_o), .dexp_o(dexp_o), .achieved_o(achieved_o)
    );

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc >= 190000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: run hung, got cycle %0d expected < 190000", cyc);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    task automatic chk(input string tag, input bit ok, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    function automatic longint unsigned sr(longint unsigned c, longint unsigned t,
                                           int e, int m, int d);
        return (c * (longint'(256 + m) << e)) / ((t << d) * 256);
    endfunction

    function automatic longint unsigned sb(int e, int m);
        return (longint'(256 + m) << (e + 1)) / 256;
    endfunction

    task automatic expect_fields(input bit burst, input longint unsigned v,
                                 input longint unsigned c, input longint unsigned t,
                                 output bit err, output bit slow, output int e,
                                 output int m, output int d, output longint unsigned ach);
        err = 0; slow = 0; e = 0; m = 0; d = 0; ach = 0;
        if (burst) begin
            if (v < 2 || v > 130816) begin
                err = 1;
            end else begin
                e = 15;
                while (v < (64'd1 << (e + 1))) e--;
                m = 255;
                while (v < sb(e, m)) m--;
                ach = sb(e, m);
            end
        end else if (v < sr(c, t, 0, 0, 12) || v > sr(c, t, 15, 255, 0)) begin
            err = 1;
        end else if (v <= sr(c, t, 0, 0, 0)) begin
            slow = 1;
            while (v < c / (t << d)) d++;
            m = 255;
            while (v < sr(c, t, 0, m, d)) m--;
            ach = sr(c, t, 0, m, d);
        end else begin
            e = 15;
            while (v < (c * (64'd1 << e)) / t) e--;
            m = 255;
            while (v < sr(c, t, e, m, 0)) m--;
            ach = sr(c, t, e, m, 0);
        end
    endtask

    task automatic run(input bit burst, input longint unsigned v,
                       input longint unsigned c, input longint unsigned t);
        bit xerr, xslow, junk;
        int xe, xm, xd;
        longint unsigned xach;
        string tag;
        expect_fields(burst, v, c, t, xerr, xslow, xe, xm, xd, xach);
        runs++;
        junk = !xerr && (runs % 5 == 0);
        @(negedge clk);
        start_i = 1'b1; burst_mode_i = burst;
        target_i = V_W'(v); clk_hz_i = C_W'(c); ticks_i = T_W'(t);
        @(negedge clk);
        start_i = 1'b0;
        chk("R2", busy_o === 1'b1 && done_o === 1'b0,
            $sformatf("after accept got busy=%0b done=%0b expected 1 0", busy_o, done_o));
        if (junk) begin
            // R3: stray requests while busy with different operands
            start_i = 1'b1; burst_mode_i = !burst;
            target_i = V_W'(v ^ 32'h5a5a); clk_hz_i = C_W'(c + 3); ticks_i = T_W'(t + 1);
            @(negedge clk);
            @(negedge clk);
            start_i = 1'b0;
        end
        while (done_o !== 1'b1) @(negedge clk);
        if (junk) tag = "R3";
        else if (burst) tag = "R9";
        else if (xerr) tag = "R4";
        else if (xslow) tag = "R5";
        else tag = "R6";
        chk(tag, err_o === xerr && exp_o == 4'(xe) && dexp_o == 4'(xd),
            $sformatf("v=%0d c=%0d t=%0d b=%0b got err=%0b e=%0d d=%0d expected err=%0b e=%0d d=%0d",
                      v, c, t, burst, err_o, exp_o, dexp_o, xerr, xe, xd));
        chk("R7", mant_o == 8'(xm),
            $sformatf("v=%0d c=%0d t=%0d b=%0b got m=%0d expected m=%0d", v, c, t, burst, mant_o, xm));
        chk(burst ? "R9" : "R8", longint'(achieved_o) == xach,
            $sformatf("v=%0d c=%0d t=%0d got ach=%0d expected %0d", v, c, t, achieved_o, xach));
        @(negedge clk);
        chk("R2", done_o === 1'b0 && busy_o === 1'b0,
            $sformatf("after result got done=%0b busy=%0b expected 0 0", done_o, busy_o));
    endtask

    task automatic sweep_rate(input longint unsigned c, input longint unsigned t);
        longint unsigned lo = sr(c, t, 0, 0, 12);
        longint unsigned hi = sr(c, t, 15, 255, 0);
        longint unsigned thr = c / t;
        if (lo > 0) run(1'b0, lo - 1, c, t);   // R4 just below
        run(1'b0, lo, c, t);
        run(1'b0, hi, c, t);
        run(1'b0, hi + 1, c, t);              // R4 just above
        run(1'b0, thr, c, t);                 // R5 threshold
        run(1'b0, thr + 1, c, t);             // R6 first fast value
        for (longint unsigned v = lo; v <= hi; v = v + v / 2 + 1) run(1'b0, v, c, t);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", busy_o === 1'b0 && done_o === 1'b0 && err_o === 1'b0 && exp_o == 0 &&
                  mant_o == 0 && dexp_o == 0 && achieved_o == 0,
            $sformatf("in reset got busy=%0b done=%0b err=%0b ach=%0d expected all 0",
                      busy_o, done_o, err_o, achieved_o));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", busy_o === 1'b0 && done_o === 1'b0 && err_o === 1'b0 && exp_o == 0 &&
                  mant_o == 0 && dexp_o == 0 && achieved_o == 0,
            $sformatf("after reset got busy=%0b done=%0b err=%0b ach=%0d expected all 0",
                      busy_o, done_o, err_o, achieved_o));

        sweep_rate(1000, 3);
        sweep_rate(50000, 7);
        sweep_rate(65535, 200);
        sweep_rate(777, 1);
        sweep_rate(4096, 255);

        // R9: burst mode with clock and tick inputs carrying garbage
        run(1'b1, 0, 12345, 0);
        run(1'b1, 1, 12345, 0);
        run(1'b1, 2, 999, 17);
        run(1'b1, 3, 1, 255);
        for (longint unsigned v = 4; v < 131000; v = v + v / 3 + 1) run(1'b1, v, 4321, 9);
        run(1'b1, 130815, 0, 0);
        run(1'b1, 130816, 65535, 255);
        run(1'b1, 130817, 7, 7);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule